// File: doc/BRIEF.md
# Two-Slot Packet Issue Gate

This block sits at the issue point of a statically scheduled pipeline that accepts two instructions per cycle. Fetch hands it one 64-bit packet each cycle, together with the packet's address. The lower word is the arithmetic/branch slot and the upper word is the memory slot. The block decodes both 32-bit instructions into an operation class and register fields. It rejects packets whose slots hold the wrong class or that sit at a misaligned address. It then decides which slots may leave for execution in this cycle.

Two conflicts hold instructions back. The first is a memory instruction that reads a register written by the arithmetic instruction in the same packet. Such a packet is split across two cycles. The second is an instruction in either slot that reads the destination of a load issued in the cycle just before. Such a packet waits one cycle. In both cases the block asks fetch to present the same packet again, and the vacated slot goes out as a nop. A running count of issued instructions supports measurement of instructions per cycle.

Top module: `pkt_issue_ctl`

## Requirements
- R1: Instruction fields are opcode [31:26], rs [25:21], rt [20:16] and rd [15:11]. The all-zero word is a nop. Opcode 0 is a register ALU op that reads rs and rt and writes rd. Opcodes 0x08, 0x09, 0x0A, 0x0C and 0x0D are immediate ALU ops that read rs and write rt. Opcodes 0x04 and 0x05 are branches that read rs and rt. Opcode 0x23 is a load that reads rs and writes rt. Opcode 0x2B is a store that reads rs and rt. Slot 0 (packet bits [31:0]) accepts only nop, ALU and branch. Slot 1 (packet bits [63:32]) accepts only nop, load and store. A slot that holds any other class raises `pkt_illegal`, is not issued, and leaves the other slot's issue unchanged.
- R2: A valid packet whose address has bits [2:0] not equal to zero raises `pkt_illegal`, and neither slot issues.
- R3: A legal packet without conflicts issues every non-nop slot in the same cycle, with `fetch_stall` low. A nop slot has its issue-valid bit low.
- R4: The packet is split when slot 0 writes a register that slot 1 reads, either as its address base or as its store data. In the first cycle only slot 0 issues and `fetch_stall` is high. In the next cycle, with the packet held, only slot 1 issues and `fetch_stall` is low.
- R5: After a cycle that issues a load in slot 1, a packet with either slot reading that load's destination issues nothing and raises `fetch_stall`. In the following cycle it issues normally.
- R6: Register 0 never causes a split or a load-use wait. This covers both reading it and writing it.
- R7: `issue_ins0` and `issue_ins1` carry the slot's instruction word when its issue-valid bit is set. Otherwise they carry the all-zero nop.
- R8: `issue_count` grows on each clock by the number of issue-valid bits that are set in that cycle.
- R9: Synchronous reset clears the count and any pending split or load history. A packet presented again after reset is judged afresh.
- R10: A branch in slot 0 writes no register, so it never splits a packet, even when the memory slot uses the same registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_valid | input | 1 | A packet is presented this cycle |
| pkt_addr | input | 32 | Address of the packet's slot 0 |
| pkt_word | input | 64 | Slot 0 in [31:0], slot 1 in [63:32] |
| issue_vld | output | 2 | Per-slot issue strobe, bit 0 = slot 0 |
| issue_ins0 | output | 32 | Instruction leaving slot 0, or nop |
| issue_ins1 | output | 32 | Instruction leaving slot 1, or nop |
| fetch_stall | output | 1 | Fetch must present the same packet again |
| pkt_illegal | output | 1 | Wrong slot class or misaligned packet |
| issue_count | output | 16 | Running count of issued instructions |

## Verification
The hardest state to reach is the second half of a split packet, and especially a reset that lands between its two halves. Only a packet whose arithmetic result feeds the memory slot gets there, and fetch must then hold that packet. The stimulus builds such packets through both the base register and the store data register. It replays the held packet, and in one run it asserts reset between the halves, then checks that the replayed packet starts a fresh split. Load-use waits are reached the same way: a load-only packet is followed by a consumer in each slot in turn, and also by a consumer of register 0.

// File: rtl/pic_pkg.sv
package pic_pkg;

    localparam int IW      = 32;
    localparam int AW      = 32;
    localparam int RW      = 5;
    localparam int NSLOT   = 2;
    localparam int ALIGN_B = 3;

    localparam logic [5:0] OP_REG   = 6'h00;
    localparam logic [5:0] OP_BEQ   = 6'h04;
    localparam logic [5:0] OP_BNE   = 6'h05;
    localparam logic [5:0] OP_ADDI  = 6'h08;
    localparam logic [5:0] OP_ADDIU = 6'h09;
    localparam logic [5:0] OP_SLTI  = 6'h0A;
    localparam logic [5:0] OP_ANDI  = 6'h0C;
    localparam logic [5:0] OP_ORI   = 6'h0D;
    localparam logic [5:0] OP_LW    = 6'h23;
    localparam logic [5:0] OP_SW    = 6'h2B;

    typedef enum logic [2:0] {
        CL_NOP, CL_ALU, CL_BR, CL_LD, CL_ST, CL_BAD
    } iclass_e;

    typedef struct packed {
        iclass_e         cls;
        logic            use_a;
        logic [RW-1:0]   src_a;
        logic            use_b;
        logic [RW-1:0]   src_b;
        logic            wr;
        logic [RW-1:0]   dst;
    } idec_t;

    function automatic idec_t nop_dec();
        idec_t d;
        d     = '0;
        d.cls = CL_NOP;
        return d;
    endfunction

    // Register 0 is filtered here so no consumer ever sees it as a dependence.
    function automatic idec_t decode(logic [IW-1:0] w);
        idec_t         d;
        logic [RW-1:0] rs, rt, rd;
        rs = w[25:21];
        rt = w[20:16];
        rd = w[15:11];
        d  = nop_dec();
        if (w != '0) begin
            d.cls = CL_BAD;
            unique case (w[31:26])
                OP_REG: begin
                    d.cls = CL_ALU;
                    d.use_a = (rs != '0); d.src_a = rs;
                    d.use_b = (rt != '0); d.src_b = rt;
                    d.wr    = (rd != '0); d.dst   = rd;
                end
                OP_ADDI, OP_ADDIU, OP_SLTI, OP_ANDI, OP_ORI: begin
                    d.cls = CL_ALU;
                    d.use_a = (rs != '0); d.src_a = rs;
                    d.wr    = (rt != '0); d.dst   = rt;
                end
                OP_BEQ, OP_BNE: begin
                    d.cls = CL_BR;
                    d.use_a = (rs != '0); d.src_a = rs;
                    d.use_b = (rt != '0); d.src_b = rt;
                end
                OP_LW: begin
                    d.cls = CL_LD;
                    d.use_a = (rs != '0); d.src_a = rs;
                    d.wr    = (rt != '0); d.dst   = rt;
                end
                OP_SW: begin
                    d.cls = CL_ST;
                    d.use_a = (rs != '0); d.src_a = rs;
                    d.use_b = (rt != '0); d.src_b = rt;
                end
                default: d.cls = CL_BAD;
            endcase
        end
        return d;
    endfunction

    function automatic logic reads_reg(idec_t d, logic [RW-1:0] r);
        return (d.use_a && d.src_a == r) || (d.use_b && d.src_b == r);
    endfunction

endpackage

// File: rtl/slot_decoder.sv
module slot_decoder
    import pic_pkg::*;
#(
    parameter int SLOT = 0
) (
    input  logic [IW-1:0] word,
    input  logic          en,
    output idec_t         dec,
    output logic          bad
);
    idec_t raw;
    logic  class_ok;

    assign raw = decode(word);

    generate
        if (SLOT == 0) begin : g_alu_slot
            assign class_ok = (raw.cls == CL_NOP) || (raw.cls == CL_ALU) || (raw.cls == CL_BR);
        end else begin : g_mem_slot
            assign class_ok = (raw.cls == CL_NOP) || (raw.cls == CL_LD) || (raw.cls == CL_ST);
        end
    endgenerate

    assign bad = en && !class_ok;
    assign dec = (en && class_ok) ? raw : nop_dec();

endmodule

// File: rtl/hazard_unit.sv
module hazard_unit
    import pic_pkg::*;
(
    input  idec_t         d0,
    input  idec_t         d1,
    input  logic          ld_vld,
    input  logic [RW-1:0] ld_dst,
    output logic          intra_hit,
    output logic          lu_hit
);
    assign intra_hit = d0.wr && reads_reg(d1, d0.dst);
    assign lu_hit    = ld_vld && (reads_reg(d0, ld_dst) || reads_reg(d1, ld_dst));
endmodule

// File: rtl/pkt_issue_ctl.sv
module pkt_issue_ctl
    import pic_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                pkt_valid,
    input  logic [AW-1:0]       pkt_addr,
    input  logic [NSLOT*IW-1:0] pkt_word,
    output logic [NSLOT-1:0]    issue_vld,
    output logic [IW-1:0]       issue_ins0,
    output logic [IW-1:0]       issue_ins1,
    output logic                fetch_stall,
    output logic                pkt_illegal,
    output logic [CNT_W-1:0]    issue_count
);
    idec_t            dec [NSLOT];
    logic [NSLOT-1:0] bad;
    logic [NSLOT-1:0] live;
    logic             misalign, pkt_ok;
    logic             intra_hit, lu_hit;
    logic             pend_q, pend_d;
    logic             ld_vld_q;
    logic [RW-1:0]    ld_dst_q;

    assign misalign = |pkt_addr[ALIGN_B-1:0];
    assign pkt_ok   = pkt_valid && !misalign;

    generate
        for (genvar s = 0; s < NSLOT; s++) begin : g_dec
            slot_decoder #(.SLOT(s)) u_dec (
                .word (pkt_word[s*IW +: IW]),
                .en   (pkt_ok),
                .dec  (dec[s]),
                .bad  (bad[s])
            );
            assign live[s] = (dec[s].cls != CL_NOP);
        end
    endgenerate

    hazard_unit u_hz (
        .d0        (dec[0]),
        .d1        (dec[1]),
        .ld_vld    (ld_vld_q),
        .ld_dst    (ld_dst_q),
        .intra_hit (intra_hit),
        .lu_hit    (lu_hit)
    );

    assign pkt_illegal = pkt_valid && (misalign || (|bad));

    always_comb begin
        issue_vld   = '0;
        fetch_stall = 1'b0;
        pend_d      = pend_q;
        if (pend_q) begin
            if (pkt_ok) begin
                issue_vld[1] = live[1];
                pend_d       = 1'b0;
            end
        end else if (pkt_ok) begin
            if (lu_hit) begin
                fetch_stall = 1'b1;
            end else if (intra_hit) begin
                issue_vld[0] = live[0];
                fetch_stall  = 1'b1;
                pend_d       = 1'b1;
            end else begin
                issue_vld = live;
            end
        end
    end

    assign issue_ins0 = issue_vld[0] ? pkt_word[IW-1:0]    : '0;
    assign issue_ins1 = issue_vld[1] ? pkt_word[2*IW-1:IW] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q      <= 1'b0;
            ld_vld_q    <= 1'b0;
            ld_dst_q    <= '0;
            issue_count <= '0;
        end else begin
            pend_q      <= pend_d;
            ld_vld_q    <= issue_vld[1] && (dec[1].cls == CL_LD) && dec[1].wr;
            ld_dst_q    <= dec[1].dst;
            issue_count <= issue_count + CNT_W'(issue_vld[0]) + CNT_W'(issue_vld[1]);
        end
    end

    assert_slot1_mem_R1: assert property (@(posedge clk) disable iff (rst)
        issue_vld[1] |-> (issue_ins1[31:26] == OP_LW || issue_ins1[31:26] == OP_SW));

    assert_misalign_block_R2: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && misalign) |-> (pkt_illegal && issue_vld == '0));

    assert_split_order_R4: assert property (@(posedge clk) disable iff (rst)
        (fetch_stall && issue_vld[0]) |=> (!issue_vld[0] && !fetch_stall));

    assert_loaduse_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (lu_hit && !pend_q) |-> (fetch_stall && issue_vld == '0));

    assert_count_step_R8: assert property (@(posedge clk) disable iff (rst)
        !rst |=> issue_count == $past(issue_count) + CNT_W'($countones($past(issue_vld))));

endmodule

// File: tb/pkt_issue_ctl_tb.sv
`timescale 1ns/1ps
module pkt_issue_ctl_tb;
    import pic_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pv  = 1'b0;
    logic [31:0] pa  = '0;
    logic [63:0] pw  = '0;
    logic [1:0]  vld;
    logic [31:0] ins0, ins1;
    logic        stall, ill;
    logic [15:0] cnt;

    int n_chk   = 0;
    int n_fail  = 0;
    int exp_cnt = 0;

    always #2 clk = ~clk;

    pkt_issue_ctl u_dut (
        .clk(clk), .rst(rst), .pkt_valid(pv), .pkt_addr(pa), .pkt_word(pw),
        .issue_vld(vld), .issue_ins0(ins0), .issue_ins1(ins1),
        .fetch_stall(stall), .pkt_illegal(ill), .issue_count(cnt)
    );

    // Row layout: addr[99:68] slot0[67:36] slot1[35:4] vld[3:2] stall[1] illegal[0]
    localparam logic [99:0] VEC [10] = '{
        {32'h100, 32'h00221820, 32'h8CC50000, 2'b11, 1'b0, 1'b0},  // add + lw
        {32'h108, 32'h10220003, 32'hAD070004, 2'b11, 1'b0, 1'b0},  // beq + sw
        {32'h110, 32'h20290005, 32'h00000000, 2'b01, 1'b0, 1'b0},  // addi + nop
        {32'h118, 32'h00000000, 32'h8CC50000, 2'b10, 1'b0, 1'b0},  // nop + lw
        {32'h120, 32'h8CC50000, 32'hAD070004, 2'b10, 1'b0, 1'b1},  // lw in slot 0
        {32'h128, 32'h00221820, 32'h20290005, 2'b01, 1'b0, 1'b1},  // addi in slot 1
        {32'h104, 32'h00221820, 32'h8CC50000, 2'b00, 1'b0, 1'b1},  // misaligned
        {32'h130, 32'h00000000, 32'h00000000, 2'b00, 1'b0, 1'b0},  // both nop
        {32'h138, 32'h20200005, 32'h8C050000, 2'b11, 1'b0, 1'b0},  // writes $0, base $0
        {32'h140, 32'h10220003, 32'hAC410000, 2'b11, 1'b0, 1'b0}   // beq $1,$2 + sw $1,0($2)
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic [31:0] a, input logic [31:0] s0,
                        input logic [31:0] s1, input logic [1:0] ev, input logic es,
                        input logic ei, input string req);
        @(negedge clk);
        chk(cnt == 16'(exp_cnt), "R8", "issue_count", 64'(cnt), 64'(exp_cnt));
        pv = v; pa = a; pw = {s1, s0};
        #1;
        chk(vld == ev,   req, "issue_vld",   64'(vld),   64'(ev));
        chk(stall == es, req, "fetch_stall", 64'(stall), 64'(es));
        chk(ill == ei,   req, "pkt_illegal", 64'(ill),   64'(ei));
        chk(ins0 == (ev[0] ? s0 : 32'h0), "R7", "issue_ins0", 64'(ins0), 64'(ev[0] ? s0 : 32'h0));
        chk(ins1 == (ev[1] ? s1 : 32'h0), "R7", "issue_ins1", 64'(ins1), 64'(ev[1] ? s1 : 32'h0));
        exp_cnt += int'(ev[0]) + int'(ev[1]);
    endtask

    task automatic idle();
        step(1'b0, 32'h0, 32'h0, 32'h0, 2'b00, 1'b0, 1'b0, "R3");
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        pv = 1'b0;
        rst = 1'b0;
        exp_cnt = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R8: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        // R9: reset state
        #1;
        chk(vld == 2'b00 && !stall, "R9", "outputs after reset", 64'({vld, stall}), 64'(0));
        chk(cnt == 16'h0, "R9", "count after reset", 64'(cnt), 64'(0));

        // R1 R2 R3 R6 R10: table, idle between rows to clear load history
        for (int i = 0; i < 10; i++) begin
            step(1'b1, VEC[i][99:68], VEC[i][67:36], VEC[i][35:4], VEC[i][3:2],
                 VEC[i][1], VEC[i][0], "R1/R2/R3/R6/R10");
            idle();
        end

        // R4: split through store data register
        step(1'b1, 32'h200, 32'h00221820, 32'hAD030000, 2'b01, 1'b1, 1'b0, "R4");
        step(1'b1, 32'h200, 32'h00221820, 32'hAD030000, 2'b10, 1'b0, 1'b0, "R4");
        idle();
        // R4: split through load base register
        step(1'b1, 32'h208, 32'h00221820, 32'h8C650000, 2'b01, 1'b1, 1'b0, "R4");
        step(1'b1, 32'h208, 32'h00221820, 32'h8C650000, 2'b10, 1'b0, 1'b0, "R4");
        idle();

        // R5: load then consumer in slot 0
        step(1'b1, 32'h210, 32'h0, 32'h8CC50000, 2'b10, 1'b0, 1'b0, "R5");
        step(1'b1, 32'h218, 32'h00A13820, 32'h0, 2'b00, 1'b1, 1'b0, "R5");
        step(1'b1, 32'h218, 32'h00A13820, 32'h0, 2'b01, 1'b0, 1'b0, "R5");
        // R5: load then consumer in slot 1
        step(1'b1, 32'h220, 32'h0, 32'h8CC50000, 2'b10, 1'b0, 1'b0, "R5");
        step(1'b1, 32'h228, 32'h0, 32'hAD050000, 2'b00, 1'b1, 1'b0, "R5");
        step(1'b1, 32'h228, 32'h0, 32'hAD050000, 2'b10, 1'b0, 1'b0, "R5");
        idle();

        // R6: load into $0 followed by a reader of $0
        step(1'b1, 32'h230, 32'h0, 32'h8CC00000, 2'b10, 1'b0, 1'b0, "R6");
        step(1'b1, 32'h238, 32'h00013820, 32'h0, 2'b01, 1'b0, 1'b0, "R6");
        idle();

        // R9: reset between the halves of a split
        step(1'b1, 32'h240, 32'h00221820, 32'hAD030000, 2'b01, 1'b1, 1'b0, "R9");
        do_reset();
        step(1'b1, 32'h240, 32'h00221820, 32'hAD030000, 2'b01, 1'b1, 1'b0, "R9");
        step(1'b1, 32'h240, 32'h00221820, 32'hAD030000, 2'b10, 1'b0, 1'b0, "R9");
        idle();
        idle();

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule